// File: doc/BRIEF.md
# Two-Wire Register Slave with Byte and Block Access

This block is the serial control port of a chip. It gives a host on a two-wire bus (SCL/SDA) access to a bank of 8-bit control registers that sit outside the block. The block answers one fixed 7-bit device address. A command byte selects the register index. Each data byte the host sends comes out as a one-cycle write strobe with the index and the data. Each byte the host reads is fetched through a read port: the block presents the index and takes the data back in the same cycle.

A command byte of 0x00 selects block transfers. A block write carries a byte count and then fills registers upward from index 0. A block read first returns a fixed count byte and then streams registers from index 0. Any other command value selects byte-command access at that index.

The index is kept between transactions. A read can therefore start at an index written in an earlier transaction, or at one written just before a repeated start. Two identification bytes are built into the block and cannot be written. Both bus lines pass through a two-flop synchroniser and are sampled on the system clock. SDA is only ever pulled low.

Top module: `smb_regslave`

## Requirements
- R1: Only an address byte whose upper seven bits equal DEV_ADDR (default 0x69, so 0xD2 to write and 0xD3 to read) is acknowledged. Any other address gets no acknowledge and no write strobe, and SDA is not driven until the next start.
- R2: In a write with a non-zero command byte, each acknowledged data byte raises `wr_en` for exactly one cycle, with `wr_idx` equal to the current index and `wr_data` equal to the byte. The first index is the command value, and the index then steps up by one after each data byte.
- R3: A write made of only the address byte and a command byte, followed by a stop, stores the command as the index and produces no write strobe.
- R4: A read returns the register at the stored index. This works whether the index was set in an earlier transaction or just before a repeated start. The index steps up by one after each byte returned.
- R5: A command byte of 0x00 selects block write. The next byte is a count N, and the following N data bytes are strobed to indices 0 to N-1. Any data byte after those N is not acknowledged and causes no strobe.
- R6: After a command byte of 0x00, a read first returns the count byte BLK_LEN (default 21, that is 0x15), then the registers starting at index 0.
- R7: Index ID0_IDX (default 19) always reads as 0x57 and index ID1_IDX (default 20) always reads as 0x21. Writes to these two indices are acknowledged but produce no write strobe.
- R8: When the master does not acknowledge a read byte, the read ends and SDA is released before the stop arrives.
- R9: The block changes its SDA drive only while SCL is low, drives SDA only to low, and releases SDA on a stop.
- R10: After reset, `sda_oe`, `wr_en` and `rd_req` are low and the block ignores the bus until a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_idx | output | 8 | Index of the register being written |
| wr_data | output | 8 | Data being written |
| rd_req | output | 1 | Read fetch from the external bank this cycle |
| rd_idx | output | 8 | Index of the register to read |
| rd_data | input | 8 | Data of register `rd_idx`, same cycle |

## Verification
Two things can meet on the same data byte. In a block write, the count running out and the write strobe decide the same acknowledge slot. In a block read, the count byte and the index reset to 0 both come from the one load that follows the read address. The bench sends one block-write byte past the count and then checks two things: that byte is not acknowledged, and the strobe log stops at exactly N entries. It then reads back the count byte followed by indices 0 to 2. A lost or extra index step shows up as a shifted data value.

// File: rtl/smb_regslave.sv
module smb_regslave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] ID0_IDX  = 8'd19,
  parameter logic [7:0] ID0_VAL  = 8'h57,
  parameter logic [7:0] ID1_IDX  = 8'd20,
  parameter logic [7:0] ID1_VAL  = 8'h21,
  parameter logic [7:0] BLK_LEN  = 8'd21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       rd_req,
  output logic [7:0] rd_idx,
  input  logic [7:0] rd_data
);

  typedef enum logic [2:0] {P_IDLE, P_ADDR, P_CMD, P_CNT, P_WDAT, P_RDAT} phase_t;

  function automatic logic is_id(input logic [7:0] x);
    return (x == ID0_IDX) || (x == ID1_IDX);
  endfunction

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  phase_t     ph;
  logic [3:0] bit_cnt;
  logic [7:0] sr, tx_sr, idx, remain;
  logic       blk;

  wire scl_s   = scl_sy[1];
  wire sda_s   = sda_sy[1];
  wire rise    = scl_s & ~scl_d;
  wire fall    = ~scl_s & scl_d;
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  wire match   = (sr[7:1] == DEV_ADDR);
  wire hdr     = (ph == P_ADDR) && blk;
  wire load_tx = fall && (bit_cnt == 4'd9) &&
                 (((ph == P_ADDR) && sr[0]) || (ph == P_RDAT)) && !start_c && !stop_c;

  logic       ack_c;
  logic [7:0] tx_byte;

  always_comb begin
    case (ph)
      P_ADDR:  ack_c = match;
      P_CMD,
      P_CNT:   ack_c = 1'b1;
      P_WDAT:  ack_c = !(blk && (remain == 8'd0));
      default: ack_c = 1'b0;
    endcase
  end

  always_comb begin
    if (hdr)                 tx_byte = BLK_LEN;
    else if (idx == ID0_IDX) tx_byte = ID0_VAL;
    else if (idx == ID1_IDX) tx_byte = ID1_VAL;
    else                     tx_byte = rd_data;
  end

  assign rd_idx = idx;
  assign rd_req = load_tx && !hdr && !is_id(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy  <= 2'b11;
      sda_sy  <= 2'b11;
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
      ph      <= P_IDLE;
      bit_cnt <= 4'd0;
      sr      <= 8'd0;
      tx_sr   <= 8'd0;
      idx     <= 8'd0;
      remain  <= 8'd0;
      blk     <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= 8'd0;
      wr_data <= 8'd0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
      wr_en  <= 1'b0;
      if (start_c) begin
        ph      <= P_ADDR;
        bit_cnt <= 4'd0;
        sda_oe  <= 1'b0;
      end else if (stop_c) begin
        ph      <= P_IDLE;
        bit_cnt <= 4'd0;
        sda_oe  <= 1'b0;
      end else if (ph == P_RDAT) begin
        if (rise && bit_cnt < 4'd8) bit_cnt <= bit_cnt + 4'd1;
        if (fall && bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
          sda_oe <= ~tx_sr[7];
          tx_sr  <= {tx_sr[6:0], 1'b0};
        end
        if (fall && bit_cnt == 4'd8) sda_oe <= 1'b0;
        if (rise && bit_cnt == 4'd8) begin
          if (!sda_s) bit_cnt <= 4'd9;
          else        ph      <= P_IDLE;
        end
        if (load_tx) begin
          sda_oe  <= ~tx_byte[7];
          tx_sr   <= {tx_byte[6:0], 1'b0};
          bit_cnt <= 4'd0;
          idx     <= idx + 8'd1;
        end
      end else if (ph != P_IDLE) begin
        if (rise && bit_cnt < 4'd8) begin
          sr      <= {sr[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end
        if (fall && bit_cnt == 4'd8) begin
          if (ack_c) begin
            sda_oe  <= 1'b1;
            bit_cnt <= 4'd9;
            case (ph)
              P_CMD: begin
                idx <= sr;
                blk <= (sr == 8'd0);
              end
              P_CNT: begin
                remain <= sr;
                idx    <= 8'd0;
              end
              P_WDAT: begin
                wr_en   <= !is_id(idx);
                wr_idx  <= idx;
                wr_data <= sr;
                idx     <= idx + 8'd1;
                if (blk) remain <= remain - 8'd1;
              end
              default: ;
            endcase
          end else begin
            ph      <= P_IDLE;
            bit_cnt <= 4'd0;
          end
        end
        if (fall && bit_cnt == 4'd9) begin
          bit_cnt <= 4'd0;
          sda_oe  <= 1'b0;
          case (ph)
            P_ADDR: begin
              if (sr[0]) begin
                ph      <= P_RDAT;
                sda_oe  <= ~tx_byte[7];
                tx_sr   <= {tx_byte[6:0], 1'b0};
                idx     <= hdr ? 8'd0 : idx + 8'd1;
              end else begin
                ph <= P_CMD;
              end
            end
            P_CMD:   ph <= blk ? P_CNT : P_WDAT;
            P_CNT:   ph <= P_WDAT;
            default: ph <= P_WDAT;
          endcase
        end
      end
    end
  end

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R2

  AST_NO_ID_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != ID0_IDX) && (wr_idx != ID1_IDX)); // R7

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == P_IDLE) |-> !sda_oe); // R1

  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == P_RDAT) && rise && (bit_cnt == 4'd8) && sda_s && !stop_c && !start_c) |=> !sda_oe); // R8

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe); // R9

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s)); // R9

endmodule

// File: tb/smb_regslave_bench.sv
module smb_regslave_bench;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_en, rd_req;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;
  logic sda_line;
  logic [7:0] mem [0:255];
  logic [7:0] log_idx [0:63];
  logic [7:0] log_dat [0:63];
  int wr_cnt = 0;
  int n_chk = 0, n_bad = 0;
  int drv_moves = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = mem[rd_idx];

  smb_regslave u_smb_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_req(rd_req), .rd_idx(rd_idx), .rd_data(rd_data));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
      if (wr_cnt < 64) begin
        log_idx[wr_cnt] <= wr_idx;
        log_dat[wr_cnt] <= wr_data;
      end
      wr_cnt <= wr_cnt + 1;
    end
  end

  logic oe_q = 1'b0;
  always @(posedge clk) begin
    oe_q <= sda_oe;
    if (rst_n && scl_m && (oe_q != sda_oe)) drv_moves <= drv_moves + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_restart();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0; tick(4);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q / 2);
    ack = ~sda_line; tick(Q / 2);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q / 2);
      b[i] = sda_line; tick(Q / 2);
      scl_m = 1'b0; tick(4);
    end
    sda_m = nack; tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(4);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R10", "sda_oe after reset", sda_oe, 0);
    chk(wr_en == 1'b0 && rd_req == 1'b0, "R10", "strobes after reset", {wr_en, rd_req}, 0);
  endtask

  task automatic t_byte_write();
    logic a1, a2, a3, a4; int c0;
    c0 = wr_cnt;
    bus_start(); send_byte(8'hD2, a1); send_byte(8'h07, a2);
    send_byte(8'h3C, a3); send_byte(8'hC3, a4); bus_stop();
    chk(a1 & a2 & a3 & a4, "R2", "acks of byte write", {a1, a2, a3, a4}, 4'hF);
    chk(wr_cnt == c0 + 2, "R2", "strobe count", wr_cnt - c0, 2);
    chk(log_idx[c0] == 8'h07 && log_dat[c0] == 8'h3C, "R2", "first strobe",
        {log_idx[c0], log_dat[c0]}, 16'h073C);
    chk(log_idx[c0+1] == 8'h08 && log_dat[c0+1] == 8'hC3, "R2", "index step strobe",
        {log_idx[c0+1], log_dat[c0+1]}, 16'h08C3);
    bus_start(); send_byte(8'hD2, a1); send_byte(8'h09, a2); send_byte(8'h5A, a3); bus_stop();
    chk(wr_cnt == c0 + 3 && log_dat[c0+2] == 8'h5A, "R2", "third write", wr_cnt - c0, 3);
  endtask

  task automatic t_bad_addr();
    logic a; int c0;
    c0 = wr_cnt;
    bus_start(); send_byte(8'hA0, a);
    chk(a == 1'b0, "R1", "ack on foreign address", a, 0);
    chk(sda_oe == 1'b0, "R1", "sda after foreign address", sda_oe, 0);
    send_byte(8'h05, a); send_byte(8'h99, a); bus_stop();
    chk(wr_cnt == c0 && a == 1'b0, "R1", "no strobe on foreign address", wr_cnt - c0, 0);
  endtask

  task automatic t_index_read();
    logic a1, a2; logic [7:0] d; int c0;
    c0 = wr_cnt;
    bus_start(); send_byte(8'hD2, a1); send_byte(8'h07, a2); bus_stop();
    chk(a1 & a2 && wr_cnt == c0, "R3", "index-only write", wr_cnt - c0, 0);
    bus_start(); send_byte(8'hD3, a1); recv_byte(1'b1, d); bus_stop();
    chk(a1 && d == 8'h3C, "R4", "read at stored index", d, 8'h3C);
  endtask

  task automatic t_restart_read();
    logic a1, a2, a3; logic [7:0] d0, d1;
    bus_start(); send_byte(8'hD2, a1); send_byte(8'h08, a2);
    bus_restart(); send_byte(8'hD3, a3);
    recv_byte(1'b0, d0); recv_byte(1'b1, d1);
    chk(sda_oe == 1'b0, "R8", "sda released after master nack", sda_oe, 0);
    bus_stop();
    chk(a1 & a2 & a3 && d0 == 8'hC3, "R4", "repeated-start read", d0, 8'hC3);
    chk(d1 == 8'h5A, "R4", "sequential read", d1, 8'h5A);
  endtask

  task automatic t_ident();
    logic a1, a2, a3, a4; logic [7:0] d0, d1; int c0;
    bus_start(); send_byte(8'hD2, a1); send_byte(8'd19, a2);
    bus_restart(); send_byte(8'hD3, a3);
    recv_byte(1'b0, d0); recv_byte(1'b1, d1); bus_stop();
    chk(d0 == 8'h57, "R7", "id byte 19", d0, 8'h57);
    chk(d1 == 8'h21, "R7", "id byte 20", d1, 8'h21);
    c0 = wr_cnt;
    bus_start(); send_byte(8'hD2, a1); send_byte(8'd19, a2);
    send_byte(8'hAA, a3); send_byte(8'h55, a4); bus_stop();
    chk(a3 & a4 && wr_cnt == c0, "R7", "id write strobes", wr_cnt - c0, 0);
    bus_start(); send_byte(8'hD2, a1); send_byte(8'd20, a2);
    bus_restart(); send_byte(8'hD3, a3); recv_byte(1'b1, d0); bus_stop();
    chk(d0 == 8'h21, "R7", "id byte 20 after write", d0, 8'h21);
  endtask

  task automatic t_block_write();
    logic a [0:6]; int c0; logic all_ok;
    c0 = wr_cnt;
    bus_start();
    send_byte(8'hD2, a[0]); send_byte(8'h00, a[1]); send_byte(8'h03, a[2]);
    send_byte(8'h11, a[3]); send_byte(8'h22, a[4]); send_byte(8'h33, a[5]);
    send_byte(8'h44, a[6]);
    bus_stop();
    all_ok = a[0] & a[1] & a[2] & a[3] & a[4] & a[5];
    chk(all_ok, "R5", "block write acks", all_ok, 1);
    chk(a[6] == 1'b0, "R5", "ack past count", a[6], 0);
    chk(wr_cnt == c0 + 3, "R5", "block strobe count", wr_cnt - c0, 3);
    chk(log_idx[c0] == 8'h00 && log_dat[c0] == 8'h11 &&
        log_idx[c0+2] == 8'h02 && log_dat[c0+2] == 8'h33, "R5", "block indices",
        {log_idx[c0+2], log_dat[c0+2]}, 16'h0233);
  endtask

  task automatic t_block_read();
    logic a1, a2, a3; logic [7:0] c, d0, d1, d2;
    bus_start(); send_byte(8'hD2, a1); send_byte(8'h00, a2);
    bus_restart(); send_byte(8'hD3, a3);
    recv_byte(1'b0, c); recv_byte(1'b0, d0); recv_byte(1'b0, d1); recv_byte(1'b1, d2);
    chk(sda_oe == 1'b0, "R8", "sda released after block nack", sda_oe, 0);
    bus_stop();
    chk(c == 8'h15, "R6", "block count byte", c, 8'h15);
    chk(d0 == 8'h11 && d1 == 8'h22 && d2 == 8'h33, "R6", "block data",
        {d0, d1, d2}, 24'h112233);
    chk(sda_line == 1'b1, "R9", "line high after stop", sda_line, 1);
    chk(drv_moves == 0, "R9", "drive moved while SCL high", drv_moves, 0);
  endtask

  initial begin
    tick(10);
    t_reset();
    rst_n = 1'b1;
    tick(10);
    t_byte_write();
    t_bad_addr();
    t_index_read();
    t_restart_read();
    t_ident();
    t_block_write();
    t_block_read();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule